// File: doc/BRIEF.md
# Neighbour-Coupled Link Energy Accumulator

This block estimates the switching energy spent on a parallel on-chip link. Each cycle in which the link carries a valid word, every wire is judged together with the wire above it and the wire below it. The block compares the last valid word with the current one and forms a 6-bit transition code for each wire. The code selects one entry of a 64-entry energy table, and the table is loaded through a simple write port. The energies of all wires are summed and added to a running 48-bit total. Because of this, a wire that toggles against a neighbour moving the other way can cost far more than one that toggles alongside it.

For each wire the block also keeps two counters. One counts how often the wire changed between valid words. The other counts the valid cycles in which the wire was high. These give the raw activity figures for a power flow next to the coupling-aware total. A small controller has two states. In ST_EMPTY no baseline word is held yet. The transition T_BASE, taken on the first valid word after reset, moves it to ST_TRACK. It stays in ST_TRACK (transition T_HOLD) until reset.

Top module: `link_energy_acc`

## Requirements
- R1: While reset is asserted and on the first cycle after it is released, `energy_total`, every toggle counter, every high counter and every table entry are zero.
- R2: The first valid word after reset (state ST_EMPTY, transition T_BASE to ST_TRACK) adds no energy and no toggles. It only becomes the previous word.
- R3: For wire i, the table index is {prev[i+1], prev[i], prev[i-1], cur[i+1], cur[i], cur[i-1]}. Bit 5 is the previous value of the upper neighbour. Bit 0 is the current value of the lower neighbour.
- R4: Wire 0 treats its missing lower neighbour as 0 in both words. Wire WIDTH-1 treats its missing upper neighbour as 0 in both words.
- R5: On each valid cycle in ST_TRACK, the looked-up entries of all WIDTH wires are added to `energy_total`. The total is unsigned and wraps modulo 2^48. The result is visible on the cycle after the clock edge.
- R6: A cycle with `link_vld` low changes neither the total nor any counter, and it leaves the previous word unchanged. Only valid words are compared with each other.
- R7: The toggle counter of wire i rises by one on each valid cycle in ST_TRACK where bit i differs from the previous valid word.
- R8: The high counter of wire i rises by one on every valid cycle where bit i is 1, including the baseline word.
- R9: When `tbl_we` is high, `tbl_wdata` is stored at `tbl_addr`. A lookup in that same cycle uses the old entry, and later lookups use the new one.
- R10: Once in ST_TRACK, the controller stays there (T_HOLD) until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| link_vld | input | 1 | Link word valid this cycle |
| link_data | input | 32 | Link word |
| tbl_we | input | 1 | Energy table write enable |
| tbl_addr | input | 6 | Table entry (transition code) to write |
| tbl_wdata | input | 16 | Unsigned energy value to write |
| energy_total | output | 48 | Running energy sum |
| toggle_cnt | output | 1024 | Toggle counters, wire i at bits [32*i+31:32*i] |
| high_cnt | output | 1024 | High-cycle counters, wire i at bits [32*i+31:32*i] |

## Verification
The table is loaded with a distinct value per code, so swapping any two code bits or any neighbour changes the sum. A full-word flip separates the all-same-direction codes. Alternating 0x5555/0xAAAA words give opposing neighbour codes. Single toggles on bits 0 and 31 expose the edge padding. Runs of random words with invalid gaps show that idle cycles neither add energy nor move the baseline. A table write issued in the same cycle as a valid word shows whether the old or the new entry is used.

// File: rtl/lee_pkg.sv
package lee_pkg;
    localparam int CODE_W = 6;
    localparam int TBL_DEPTH = 1 << CODE_W;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_TRACK = 1'b1
    } lee_state_e;
endpackage

// File: rtl/lee_code_gen.sv
module lee_code_gen
    import lee_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0]        prev_word,
    input  logic [WIDTH-1:0]        cur_word,
    output logic [WIDTH*CODE_W-1:0] codes
);
    // zero padding on both sides supplies the absent edge neighbours
    logic [WIDTH+1:0] p_pad;
    logic [WIDTH+1:0] c_pad;

    assign p_pad = {1'b0, prev_word, 1'b0};
    assign c_pad = {1'b0, cur_word, 1'b0};

    for (genvar i = 0; i < WIDTH; i++) begin : g_code
        assign codes[i*CODE_W +: CODE_W] = {p_pad[i+2], p_pad[i+1], p_pad[i],
                                            c_pad[i+2], c_pad[i+1], c_pad[i]};
    end
endmodule

// File: rtl/lee_energy_table.sv
module lee_energy_table
    import lee_pkg::*;
#(
    parameter int WIDTH   = 32,
    parameter int ENTRY_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [CODE_W-1:0]        wr_addr,
    input  logic [ENTRY_W-1:0]       wr_data,
    input  logic [WIDTH*CODE_W-1:0]  codes,
    output logic [WIDTH*ENTRY_W-1:0] energies
);
    logic [ENTRY_W-1:0] mem_q [TBL_DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < TBL_DEPTH; k++) begin
                mem_q[k] <= '0;
            end
        end else if (wr_en) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    for (genvar i = 0; i < WIDTH; i++) begin : g_rd
        assign energies[i*ENTRY_W +: ENTRY_W] = mem_q[codes[i*CODE_W +: CODE_W]];
    end
endmodule

// File: rtl/lee_sum_tree.sv
module lee_sum_tree #(
    parameter int WIDTH   = 32,
    parameter int ENTRY_W = 16,
    parameter int SUM_W   = ENTRY_W + $clog2(WIDTH) + 1
) (
    input  logic [WIDTH*ENTRY_W-1:0] terms,
    output logic [SUM_W-1:0]         total
);
    localparam int LEVELS = $clog2(WIDTH);
    localparam int LEAVES = 1 << LEVELS;

    // node n has children 2n and 2n+1; leaves occupy LEAVES..2*LEAVES-1
    logic [SUM_W-1:0] node [2*LEAVES];

    for (genvar l = 0; l < LEAVES; l++) begin : g_leaf
        if (l < WIDTH) begin : g_used
            assign node[LEAVES+l] = SUM_W'(terms[l*ENTRY_W +: ENTRY_W]);
        end else begin : g_pad
            assign node[LEAVES+l] = '0;
        end
    end

    for (genvar n = 1; n < LEAVES; n++) begin : g_node
        assign node[n] = node[2*n] + node[2*n+1];
    end

    assign node[0] = '0;
    assign total   = (LEAVES == 1) ? node[1] : node[1];
endmodule

// File: rtl/lee_wire_counters.sv
module lee_wire_counters #(
    parameter int WIDTH = 32,
    parameter int CNT_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               high_en,
    input  logic               tog_en,
    input  logic [WIDTH-1:0]   prev_word,
    input  logic [WIDTH-1:0]   cur_word,
    output logic [WIDTH*CNT_W-1:0] tog_cnt,
    output logic [WIDTH*CNT_W-1:0] high_cnt
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_wire
        logic [CNT_W-1:0] tog_q;
        logic [CNT_W-1:0] high_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tog_q  <= '0;
                high_q <= '0;
            end else begin
                if (tog_en && (prev_word[i] != cur_word[i])) begin
                    tog_q <= tog_q + 1'b1;
                end
                if (high_en && cur_word[i]) begin
                    high_q <= high_q + 1'b1;
                end
            end
        end

        assign tog_cnt[i*CNT_W +: CNT_W]  = tog_q;
        assign high_cnt[i*CNT_W +: CNT_W] = high_q;
    end
endmodule

// File: rtl/link_energy_acc.sv
module link_energy_acc
    import lee_pkg::*;
#(
    parameter int WIDTH   = 32,
    parameter int ENTRY_W = 16,
    parameter int ACC_W   = 48,
    parameter int CNT_W   = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     link_vld,
    input  logic [WIDTH-1:0]         link_data,
    input  logic                     tbl_we,
    input  logic [CODE_W-1:0]        tbl_addr,
    input  logic [ENTRY_W-1:0]       tbl_wdata,
    output logic [ACC_W-1:0]         energy_total,
    output logic [WIDTH*CNT_W-1:0]   toggle_cnt,
    output logic [WIDTH*CNT_W-1:0]   high_cnt
);
    localparam int SUM_W = ENTRY_W + $clog2(WIDTH) + 1;

    lee_state_e state_q;
    lee_state_e state_d;
    logic       acc_en;
    logic [WIDTH-1:0]        prev_q;
    logic [WIDTH*CODE_W-1:0] codes;
    logic [WIDTH*ENTRY_W-1:0] energies;
    logic [SUM_W-1:0]        cycle_sum;
    logic [ACC_W-1:0]        acc_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and outputs of the controller
    always_comb begin
        state_d = state_q;
        acc_en  = 1'b0;
        unique case (state_q)
            ST_EMPTY: begin
                if (link_vld) begin
                    state_d = ST_TRACK;
                end
            end
            ST_TRACK: begin
                acc_en = link_vld;
            end
            default: state_d = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
            acc_q  <= '0;
        end else begin
            if (link_vld) begin
                prev_q <= link_data;
            end
            if (acc_en) begin
                acc_q <= acc_q + ACC_W'(cycle_sum);
            end
        end
    end

    lee_code_gen #(.WIDTH(WIDTH)) u_code (
        .prev_word (prev_q),
        .cur_word  (link_data),
        .codes     (codes)
    );

    lee_energy_table #(.WIDTH(WIDTH), .ENTRY_W(ENTRY_W)) u_tbl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (tbl_we),
        .wr_addr  (tbl_addr),
        .wr_data  (tbl_wdata),
        .codes    (codes),
        .energies (energies)
    );

    lee_sum_tree #(.WIDTH(WIDTH), .ENTRY_W(ENTRY_W), .SUM_W(SUM_W)) u_sum (
        .terms (energies),
        .total (cycle_sum)
    );

    lee_wire_counters #(.WIDTH(WIDTH), .CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .high_en   (link_vld),
        .tog_en    (acc_en),
        .prev_word (prev_q),
        .cur_word  (link_data),
        .tog_cnt   (toggle_cnt),
        .high_cnt  (high_cnt)
    );

    assign energy_total = acc_q;
endmodule

// File: rtl/lee_checker.sv
module lee_checker
    import lee_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int ACC_W = 48,
    parameter int CNT_W = 32
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   link_vld,
    input logic [WIDTH-1:0]       link_data,
    input logic [ACC_W-1:0]       energy_total,
    input logic [WIDTH*CNT_W-1:0] toggle_cnt,
    input logic [WIDTH*CNT_W-1:0] high_cnt,
    input lee_state_e             state_q,
    input logic [WIDTH-1:0]       prev_q
);
    // R6
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !link_vld |=> $stable(energy_total) && $stable(toggle_cnt) && $stable(high_cnt));

    // R6
    idle_keeps_prev_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !link_vld |=> $stable(prev_q));

    // R2
    baseline_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EMPTY) && link_vld |=> $stable(energy_total) && $stable(toggle_cnt));

    // R10
    track_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TRACK) |=> (state_q == ST_TRACK));

    // R8
    high_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        link_vld && link_data[0] |=> high_cnt[CNT_W-1:0] == $past(high_cnt[CNT_W-1:0]) + 1'b1);

    // R7
    no_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TRACK) && link_vld && (link_data[0] == prev_q[0])
        |=> $stable(toggle_cnt[CNT_W-1:0]));
endmodule

bind link_energy_acc lee_checker #(.WIDTH(WIDTH), .ACC_W(ACC_W), .CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .link_vld     (link_vld),
    .link_data    (link_data),
    .energy_total (energy_total),
    .toggle_cnt   (toggle_cnt),
    .high_cnt     (high_cnt),
    .state_q      (state_q),
    .prev_q       (prev_q)
);

// File: tb/sim_link_energy_acc.sv
module sim_link_energy_acc;
    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          link_vld = 1'b0;
    logic [31:0]   link_data = '0;
    logic          tbl_we = 1'b0;
    logic [5:0]    tbl_addr = '0;
    logic [15:0]   tbl_wdata = '0;
    logic [47:0]   energy_total;
    logic [1023:0] toggle_cnt;
    logic [1023:0] high_cnt;

    int checks = 0;
    int errors = 0;

    // behavioural reference
    int unsigned  m_tbl [64];
    logic [31:0]  m_prev;
    bit           m_base;
    longint unsigned m_energy;
    int unsigned  m_tog [32];
    int unsigned  m_hi [32];

    always #2 clk = ~clk;

    link_energy_acc u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .link_vld     (link_vld),
        .link_data    (link_data),
        .tbl_we       (tbl_we),
        .tbl_addr     (tbl_addr),
        .tbl_wdata    (tbl_wdata),
        .energy_total (energy_total),
        .toggle_cnt   (toggle_cnt),
        .high_cnt     (high_cnt)
    );

    function automatic bit bit_at(input logic [31:0] w, input int idx);
        if (idx < 0 || idx > 31) return 1'b0;
        return w[idx];
    endfunction

    function automatic void model_reset();
        for (int k = 0; k < 64; k++) m_tbl[k] = 0;
        for (int k = 0; k < 32; k++) begin
            m_tog[k] = 0;
            m_hi[k]  = 0;
        end
        m_prev = '0;
        m_base = 1'b0;
        m_energy = 0;
    endfunction

    function automatic void model_step(input logic v, input logic [31:0] d,
                                       input logic we, input logic [5:0] a,
                                       input logic [15:0] w);
        int idx;
        if (v) begin
            if (m_base) begin
                for (int i = 0; i < 32; i++) begin
                    idx = 32 * int'(bit_at(m_prev, i + 1)) + 16 * int'(bit_at(m_prev, i))
                        + 8 * int'(bit_at(m_prev, i - 1)) + 4 * int'(bit_at(d, i + 1))
                        + 2 * int'(bit_at(d, i)) + int'(bit_at(d, i - 1));
                    m_energy += longint'(m_tbl[idx]);
                    if (m_prev[i] != d[i]) m_tog[i]++;
                end
                m_energy &= 64'h0000_FFFF_FFFF_FFFF;
            end
            for (int i = 0; i < 32; i++) if (d[i]) m_hi[i]++;
            m_prev = d;
            m_base = 1'b1;
        end
        if (we) m_tbl[a] = int'(w);
    endfunction

    task automatic compare(input string tag);
        int bad;
        checks++;
        if (energy_total != m_energy[47:0]) begin
            errors++;
            $display("FAIL %s R5 energy act %0d exp %0d", tag, energy_total, m_energy);
        end
        checks++;
        bad = -1;
        for (int i = 0; i < 32; i++)
            if (bad < 0 && toggle_cnt[i*32 +: 32] != m_tog[i]) bad = i;
        if (bad >= 0) begin
            errors++;
            $display("FAIL %s R7 toggle wire %0d act %0d exp %0d", tag, bad,
                     toggle_cnt[bad*32 +: 32], m_tog[bad]);
        end
        checks++;
        bad = -1;
        for (int i = 0; i < 32; i++)
            if (bad < 0 && high_cnt[i*32 +: 32] != m_hi[i]) bad = i;
        if (bad >= 0) begin
            errors++;
            $display("FAIL %s R8 high wire %0d act %0d exp %0d", tag, bad,
                     high_cnt[bad*32 +: 32], m_hi[bad]);
        end
    endtask

    task automatic step(input logic v, input logic [31:0] d, input logic we,
                        input logic [5:0] a, input logic [15:0] w, input string tag);
        link_vld  = v;
        link_data = d;
        tbl_we    = we;
        tbl_addr  = a;
        tbl_wdata = w;
        @(posedge clk);
        model_step(v, d, we, a, w);
        @(negedge clk);
        compare(tag);
    endtask

    task automatic word(input logic [31:0] d, input string tag);
        step(1'b1, d, 1'b0, 6'd0, 16'd0, tag);
    endtask

    task automatic idle(input logic [31:0] d, input string tag);
        step(1'b0, d, 1'b0, 6'd0, 16'd0, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R10 watchdog act running exp finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        compare("R1 reset");
        rst_n = 1'b1;
        @(negedge clk);
        compare("R1 after release");

        // R9: load a distinct value per code, link idle
        for (int k = 0; k < 64; k++)
            step(1'b0, 32'hFFFF_FFFF, 1'b1, 6'(k), 16'(k * 97 + 5), "R9 R6 load");

        // R2: baseline word
        word(32'h0000_0000, "R2 baseline");
        checks++;
        if (energy_total != 48'd0) begin
            errors++;
            $display("FAIL R2 baseline energy act %0d exp 0", energy_total);
        end

        // R3 R5: all-same-direction flips
        word(32'hFFFF_FFFF, "R3 rise all");
        word(32'h0000_0000, "R3 fall all");
        // R3: opposing neighbours
        word(32'h5555_5555, "R3 alt");
        word(32'hAAAA_AAAA, "R3 alt swap");
        word(32'h5555_5555, "R3 alt back");
        // R4: edge wires alone
        word(32'h0000_0000, "R4 clear");
        word(32'h0000_0001, "R4 bit0 up");
        word(32'h8000_0000, "R4 bit31 up");
        word(32'h8000_0001, "R4 both");
        // walking one
        for (int i = 0; i < 32; i++) word(32'h1 << i, "R3 walk");

        // R6: idle cycles with changing data do not move baseline
        idle(32'h1234_5678, "R6 idle a");
        idle(32'hFFFF_0000, "R6 idle b");
        word(32'h8000_0000, "R6 resume");

        // R9: write the entry in use during the same valid cycle
        word(32'h0000_0000, "R9 prep");
        step(1'b1, 32'h0000_0000, 1'b1, 6'd0, 16'd1000, "R9 same cycle old");
        word(32'h0000_0000, "R9 next new");

        // random traffic with gaps
        for (int n = 0; n < 300; n++) begin
            if (($urandom % 4) == 0) idle($urandom, "R6 rand idle");
            else word($urandom, "R5 R7 R8 rand");
        end

        // R10: reset again returns to empty, next word is baseline
        rst_n = 1'b0;
        @(posedge clk);
        model_reset();
        @(negedge clk);
        compare("R1 re-reset");
        rst_n = 1'b1;
        step(1'b0, 32'h0, 1'b1, 6'd63, 16'hFFFF, "R9 reload");
        word(32'hFFFF_FFFF, "R2 R10 new baseline");
        word(32'hFFFF_FFFF, "R10 track");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule